// File: doc/BRIEF.md
# Device Event Log Queue

This block is a small hardware event log. It buffers fixed-size event records in the order they arrive. Each accepted record is tagged with a nonzero handle, taken from a counter that never issues zero, and with the value of a timestamp input at the moment of insertion. The log is bounded. An insert that arrives when the log is full is dropped. The block then records the drop as an overflow, keeping a count, the time of the first drop and the time of the latest drop.

A host has two ways to work on the log. A read returns up to a requested number of records, starting at the oldest, and leaves the log unchanged. The records stream out one per cycle, followed by a completion beat that carries the number returned, a more-records flag and any overflow data. A clear names a list of handles. The block checks the whole list against the records, starting from the oldest, before it removes anything. If every handle matches in order, that many records leave the log. Otherwise the request is refused and nothing is removed.

Insert, read and clear are serialized by a single fixed-priority arbiter: clear first, then read, then insert. A port that loses, or that asks while a read is streaming, sees its stall output high. Its request is taken only in a cycle where its stall is low. The block also drives a level status flag and a one-cycle interrupt request for the moment the log stops being empty.

Top module: `evlog_queue`

## Requirements
- R1: The log holds at most DEPTH (default 8) records. An insert taken while DEPTH records are held stores nothing and counts as an overflow.
- R2: On each overflow the overflow count rises by one and the last-overflow time takes `ins_ts`. The first-overflow time takes `ins_ts` only when the count was zero before that overflow.
- R3: Handles start at 1 after reset and advance by one per accepted record. When the counter wraps to zero it skips to 1, so handle 0 is never issued.
- R4: An accepted record keeps `ins_data`, is stamped with `ins_ts`, and is appended after all records already held.
- R5: `irq_req` is high for exactly one cycle, the cycle after an accepted insert that takes the record count from 0 to 1. It is low at every other time.
- R6: `log_status` goes high on any accepted insert. It goes low when a clear leaves the log empty, and it stays low from reset until the first insert.
- R7: A read taken at edge E streams min(`rd_max`, held) records, oldest first, with `rec_valid` high in the n cycles after E. `rd_done` is high in the following cycle with `rd_num` = n. A read removes nothing.
- R8: On the `rd_done` beat, `rd_more` is 1 exactly when the log holds at least one record. `rd_ovf` is 1 exactly when the overflow count is nonzero, and in that case the count and both overflow times appear on the overflow outputs.
- R9: A clear compares handle slot i (bits i*HANDLE_W upward of `clr_handles`) with the i-th oldest record, for i below min(`clr_num`, held). If any compared slot is zero or differs, `clr_code` = 1 (invalid input) and no record is removed.
- R10: A validated clear returns `clr_code` = 0 and removes min(`clr_num`, held) records from the oldest end. Any clear that removes at least one record resets the overflow count and both overflow times to zero.
- R11: A clear whose `clr_num` exceeds the number of held records checks and removes only the records present, and it reports success.
- R12: `clr_req` forces `rd_stall` and `ins_stall` high. `rd_req` forces `ins_stall` high. All three stalls are high while a read is streaming or completing. A clear is answered by `clr_done` in the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_req | input | 1 | Insert request, held until taken |
| ins_data | input | DATA_W | Record payload |
| ins_ts | input | TS_W | Current timestamp for stamping and overflow times |
| ins_stall | output | 1 | Insert not taken this cycle |
| rd_req | input | 1 | Read request, held until taken |
| rd_max | input | CNT_W | Maximum number of records to return |
| rd_stall | output | 1 | Read not taken this cycle |
| rec_valid | output | 1 | A streamed record is present |
| rec_data | output | DATA_W | Streamed record payload |
| rec_handle | output | HANDLE_W | Streamed record handle |
| rec_ts | output | TS_W | Streamed record timestamp |
| rd_done | output | 1 | Read completion beat |
| rd_num | output | CNT_W | Number of records returned |
| rd_more | output | 1 | Log non-empty at completion |
| rd_ovf | output | 1 | Overflow count nonzero at completion |
| rd_ovf_cnt | output | OVF_W | Overflow count (valid with rd_ovf) |
| rd_ovf_first | output | TS_W | First-overflow time (valid with rd_ovf) |
| rd_ovf_last | output | TS_W | Last-overflow time (valid with rd_ovf) |
| clr_req | input | 1 | Clear request, held until taken |
| clr_num | input | CNT_W | Number of handles in the clear list |
| clr_handles | input | DEPTH*HANDLE_W | Handle list, slot i at bits i*HANDLE_W |
| clr_stall | output | 1 | Clear not taken this cycle |
| clr_done | output | 1 | Clear answer beat |
| clr_code | output | 2 | 0 success, 1 invalid input |
| log_status | output | 1 | Log holds records |
| irq_req | output | 1 | One-cycle pulse when the log becomes non-empty |

## Verification
An insert or a clear that is taken at edge E shows its effect right after E. This covers `irq_req`, `log_status`, `clr_done` with `clr_code`, and the new record count, so the bench samples these at the falling edge that follows E. A read taken at E puts record j on the stream between edges E+j and E+j+1, with `rd_done` after edge E+n. The bench walks the stream one falling edge at a time and compares each beat with its own queue model. The stall outputs are combinational from the requests, so the bench checks them shortly after it changes a request and before the next rising edge. It uses this to step through a three-way collision one grant at a time.

// File: rtl/evlog_pkg.sv
`timescale 1ns/1ps
package evlog_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_DONE = 2'd2
  } evlog_state_e;

  localparam logic [1:0] CLR_OK        = 2'd0;
  localparam logic [1:0] CLR_BAD_INPUT = 2'd1;
endpackage

// File: rtl/evlog_handle_gen.sv
`timescale 1ns/1ps
module evlog_handle_gen #(
  parameter int HANDLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  output logic [HANDLE_W-1:0] cur_hdl
);
  localparam logic [HANDLE_W-1:0] FIRST_HDL = HANDLE_W'(1);

  // next handle value, zero is skipped
  function automatic logic [HANDLE_W-1:0] bump(input logic [HANDLE_W-1:0] h);
    logic [HANDLE_W-1:0] n;
    n = h + 1'b1;
    if (n == '0) n = FIRST_HDL;
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   cur_hdl <= FIRST_HDL;
    else if (adv) cur_hdl <= bump(cur_hdl);
  end
endmodule

// File: rtl/evlog_overflow.sv
`timescale 1ns/1ps
module evlog_overflow #(
  parameter int TS_W  = 32,
  parameter int OVF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovf_evt,
  input  logic             wipe,
  input  logic [TS_W-1:0]  ts_now,
  output logic [OVF_W-1:0] ovf_cnt,
  output logic [TS_W-1:0]  ovf_first,
  output logic [TS_W-1:0]  ovf_last
);
  localparam logic [OVF_W-1:0] CNT_MAX = '1;

  function automatic logic [OVF_W-1:0] sat_inc(input logic [OVF_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      ovf_cnt   <= '0;
      ovf_first <= '0;
      ovf_last  <= '0;
    end else if (ovf_evt) begin
      if (ovf_cnt == '0) ovf_first <= ts_now;
      ovf_cnt  <= sat_inc(ovf_cnt);
      ovf_last <= ts_now;
    end
  end
endmodule

// File: rtl/evlog_store.sv
`timescale 1ns/1ps
module evlog_store #(
  parameter int DEPTH    = 8,
  parameter int DATA_W   = 32,
  parameter int HANDLE_W = 16,
  parameter int TS_W     = 32,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [DATA_W-1:0]         push_data,
  input  logic [HANDLE_W-1:0]       push_hdl,
  input  logic [TS_W-1:0]           push_ts,
  input  logic                      pop,
  input  logic [CNT_W-1:0]          pop_n,
  input  logic [CNT_W-1:0]          peek_idx,
  output logic [DATA_W-1:0]         peek_data,
  output logic [HANDLE_W-1:0]       peek_hdl,
  output logic [TS_W-1:0]           peek_ts,
  output logic [DEPTH*HANDLE_W-1:0] head_hdls,
  output logic [CNT_W-1:0]          count
);
  logic [DATA_W-1:0]   data_mem [DEPTH];
  logic [HANDLE_W-1:0] hdl_mem  [DEPTH];
  logic [TS_W-1:0]     ts_mem   [DEPTH];
  logic [PTR_W-1:0]    head, tail;

  // ring pointer advance by k slots
  function automatic logic [PTR_W-1:0] ptr_add(input logic [PTR_W-1:0] p,
                                               input logic [CNT_W-1:0] k);
    int unsigned s;
    s = int'(p) + int'(k);
    return PTR_W'(s % DEPTH);
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      data_mem[tail] <= push_data;
      hdl_mem[tail]  <= push_hdl;
      ts_mem[tail]   <= push_ts;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (push) begin
      tail  <= ptr_add(tail, CNT_W'(1));
      count <= count + 1'b1;
    end else if (pop) begin
      head  <= ptr_add(head, pop_n);
      count <= count - pop_n;
    end
  end

  assign peek_data = data_mem[ptr_add(head, peek_idx)];
  assign peek_hdl  = hdl_mem[ptr_add(head, peek_idx)];
  assign peek_ts   = ts_mem[ptr_add(head, peek_idx)];

  for (genvar i = 0; i < DEPTH; i++) begin : g_head
    assign head_hdls[i*HANDLE_W +: HANDLE_W] = hdl_mem[ptr_add(head, CNT_W'(i))];
  end
endmodule

// File: rtl/evlog_arbiter.sv
`timescale 1ns/1ps
module evlog_arbiter (
  input  logic clr_req,
  input  logic rd_req,
  input  logic ins_req,
  input  logic busy,
  output logic clr_go,
  output logic rd_go,
  output logic ins_go,
  output logic clr_stall,
  output logic rd_stall,
  output logic ins_stall
);
  // fixed order: clear, read, insert
  assign clr_stall = busy;
  assign rd_stall  = busy | clr_req;
  assign ins_stall = busy | clr_req | rd_req;

  assign clr_go = clr_req & ~clr_stall;
  assign rd_go  = rd_req  & ~rd_stall;
  assign ins_go = ins_req & ~ins_stall;
endmodule

// File: rtl/evlog_queue.sv
`timescale 1ns/1ps
module evlog_queue
  import evlog_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int DATA_W   = 32,
  parameter int HANDLE_W = 16,
  parameter int TS_W     = 32,
  parameter int OVF_W    = 16,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ins_req,
  input  logic [DATA_W-1:0]         ins_data,
  input  logic [TS_W-1:0]           ins_ts,
  output logic                      ins_stall,
  input  logic                      rd_req,
  input  logic [CNT_W-1:0]          rd_max,
  output logic                      rd_stall,
  output logic                      rec_valid,
  output logic [DATA_W-1:0]         rec_data,
  output logic [HANDLE_W-1:0]       rec_handle,
  output logic [TS_W-1:0]           rec_ts,
  output logic                      rd_done,
  output logic [CNT_W-1:0]          rd_num,
  output logic                      rd_more,
  output logic                      rd_ovf,
  output logic [OVF_W-1:0]          rd_ovf_cnt,
  output logic [TS_W-1:0]           rd_ovf_first,
  output logic [TS_W-1:0]           rd_ovf_last,
  input  logic                      clr_req,
  input  logic [CNT_W-1:0]          clr_num,
  input  logic [DEPTH*HANDLE_W-1:0] clr_handles,
  output logic                      clr_stall,
  output logic                      clr_done,
  output logic [1:0]                clr_code,
  output logic                      log_status,
  output logic                      irq_req
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  function automatic logic [CNT_W-1:0] take_min(input logic [CNT_W-1:0] a,
                                                input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  evlog_state_e state;
  logic [CNT_W-1:0] cnt, rd_idx, rd_total, clr_take;
  logic clr_go, rd_go, ins_go, busy;
  logic push, pop, ovf_evt, full, clr_valid;
  logic [HANDLE_W-1:0] push_hdl;
  logic [DEPTH*HANDLE_W-1:0] head_hdls;
  logic [DEPTH-1:0] slot_ok;
  logic [OVF_W-1:0] ovf_cnt;
  logic [TS_W-1:0]  ovf_first, ovf_last;

  assign busy = (state != ST_IDLE);

  evlog_arbiter u_arb (
    .clr_req(clr_req), .rd_req(rd_req), .ins_req(ins_req), .busy(busy),
    .clr_go(clr_go), .rd_go(rd_go), .ins_go(ins_go),
    .clr_stall(clr_stall), .rd_stall(rd_stall), .ins_stall(ins_stall)
  );

  // clear validation: all compared slots in parallel
  assign clr_take = take_min(clr_num, cnt);
  for (genvar i = 0; i < DEPTH; i++) begin : g_val
    logic [HANDLE_W-1:0] want, have;
    assign want = clr_handles[i*HANDLE_W +: HANDLE_W];
    assign have = head_hdls[i*HANDLE_W +: HANDLE_W];
    assign slot_ok[i] = (CNT_W'(i) >= clr_take) || ((want != '0) && (want == have));
  end
  assign clr_valid = &slot_ok;

  assign full    = (cnt == FULL_CNT);
  assign push    = ins_go & ~full;
  assign ovf_evt = ins_go & full;
  assign pop     = clr_go & clr_valid & (clr_take != '0);

  evlog_handle_gen #(.HANDLE_W(HANDLE_W)) u_hdl (
    .clk(clk), .rst_n(rst_n), .adv(push), .cur_hdl(push_hdl)
  );

  evlog_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .HANDLE_W(HANDLE_W), .TS_W(TS_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_data(ins_data), .push_hdl(push_hdl), .push_ts(ins_ts),
    .pop(pop), .pop_n(clr_take),
    .peek_idx(rd_idx), .peek_data(rec_data), .peek_hdl(rec_handle), .peek_ts(rec_ts),
    .head_hdls(head_hdls), .count(cnt)
  );

  evlog_overflow #(.TS_W(TS_W), .OVF_W(OVF_W)) u_ovf (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .wipe(pop), .ts_now(ins_ts),
    .ovf_cnt(ovf_cnt), .ovf_first(ovf_first), .ovf_last(ovf_last)
  );

  // read sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rd_idx   <= '0;
      rd_total <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (rd_go) begin
          rd_idx   <= '0;
          rd_total <= take_min(rd_max, cnt);
          state    <= (take_min(rd_max, cnt) == '0) ? ST_DONE : ST_READ;
        end
        ST_READ: begin
          if (rd_idx == rd_total - 1'b1) state <= ST_DONE;
          else                           rd_idx <= rd_idx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rec_valid    = (state == ST_READ);
  assign rd_done      = (state == ST_DONE);
  assign rd_num       = rd_total;
  assign rd_more      = rd_done & (cnt != '0);
  assign rd_ovf       = rd_done & (ovf_cnt != '0);
  assign rd_ovf_cnt   = rd_ovf ? ovf_cnt   : '0;
  assign rd_ovf_first = rd_ovf ? ovf_first : '0;
  assign rd_ovf_last  = rd_ovf ? ovf_last  : '0;

  // clear answer, status and interrupt
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_done   <= 1'b0;
      clr_code   <= CLR_OK;
      log_status <= 1'b0;
      irq_req    <= 1'b0;
    end else begin
      clr_done <= clr_go;
      if (clr_go) clr_code <= clr_valid ? CLR_OK : CLR_BAD_INPUT;
      if (push)                           log_status <= 1'b1;
      else if (pop && (cnt == clr_take))  log_status <= 1'b0;
      irq_req <= push && (cnt == '0);
    end
  end
endmodule

// File: rtl/evlog_queue_chk.sv
`timescale 1ns/1ps
module evlog_queue_chk
  import evlog_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int HANDLE_W = 16,
  parameter int OVF_W    = 16,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CNT_W-1:0]    cnt,
  input logic                push,
  input logic                pop,
  input logic                ovf_evt,
  input logic [HANDLE_W-1:0] push_hdl,
  input logic [OVF_W-1:0]    ovf_cnt,
  input logic                irq_req,
  input logic                log_status,
  input logic                rec_valid,
  input logic                clr_done,
  input logic [1:0]          clr_code,
  input logic                clr_req,
  input logic                rd_req,
  input logic                ins_stall,
  input logic                rd_stall
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [OVF_W-1:0] OVF_MAX  = '1;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL_CNT); // R1
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n) ovf_evt |=> cnt == FULL_CNT); // R1
  AST_OVF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && ovf_cnt != OVF_MAX) |=> ovf_cnt == $past(ovf_cnt) + 1'b1); // R2
  AST_HANDLE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) push |-> push_hdl != '0); // R3
  AST_IRQ_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (cnt == CNT_W'(1)) && ($past(cnt) == '0)); // R5
  AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) log_status == (cnt != '0)); // R6
  AST_READ_NO_POP: assert property (@(posedge clk) disable iff (!rst_n) rec_valid |-> !pop && !push); // R7
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && clr_code == CLR_BAD_INPUT) |-> cnt == $past(cnt)); // R9
  AST_POP_WIPES_OVF: assert property (@(posedge clk) disable iff (!rst_n) pop |=> ovf_cnt == '0); // R10
  AST_CLR_FIRST: assert property (@(posedge clk) disable iff (!rst_n) clr_req |-> ins_stall && rd_stall); // R12
  AST_RD_OVER_INS: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> ins_stall); // R12
endmodule

bind evlog_queue evlog_queue_chk #(.DEPTH(DEPTH), .HANDLE_W(HANDLE_W), .OVF_W(OVF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .push(push), .pop(pop), .ovf_evt(ovf_evt),
  .push_hdl(push_hdl), .ovf_cnt(ovf_cnt), .irq_req(irq_req), .log_status(log_status),
  .rec_valid(rec_valid), .clr_done(clr_done), .clr_code(clr_code), .clr_req(clr_req),
  .rd_req(rd_req), .ins_stall(ins_stall), .rd_stall(rd_stall)
);

// File: tb/evlog_queue_bench.sv
`timescale 1ns/1ps
module evlog_queue_bench;
  localparam int D  = 8;
  localparam int HW = 4;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_req = 0, rd_req = 0, clr_req = 0;
  logic [31:0] ins_data = '0, ins_ts = '0;
  logic [CW-1:0] rd_max = '0, clr_num = '0;
  logic [D*HW-1:0] clr_handles = '0;
  logic ins_stall, rd_stall, clr_stall, rec_valid, rd_done, rd_more, rd_ovf;
  logic clr_done, log_status, irq_req;
  logic [31:0] rec_data, rec_ts, rd_ovf_first, rd_ovf_last;
  logic [HW-1:0] rec_handle;
  logic [CW-1:0] rd_num;
  logic [15:0] rd_ovf_cnt;
  logic [1:0] clr_code;

  evlog_queue #(.DEPTH(D), .DATA_W(32), .HANDLE_W(HW), .TS_W(32), .OVF_W(16)) u_evlog_queue (
    .clk(clk), .rst_n(rst_n),
    .ins_req(ins_req), .ins_data(ins_data), .ins_ts(ins_ts), .ins_stall(ins_stall),
    .rd_req(rd_req), .rd_max(rd_max), .rd_stall(rd_stall),
    .rec_valid(rec_valid), .rec_data(rec_data), .rec_handle(rec_handle), .rec_ts(rec_ts),
    .rd_done(rd_done), .rd_num(rd_num), .rd_more(rd_more), .rd_ovf(rd_ovf),
    .rd_ovf_cnt(rd_ovf_cnt), .rd_ovf_first(rd_ovf_first), .rd_ovf_last(rd_ovf_last),
    .clr_req(clr_req), .clr_num(clr_num), .clr_handles(clr_handles), .clr_stall(clr_stall),
    .clr_done(clr_done), .clr_code(clr_code), .log_status(log_status), .irq_req(irq_req)
  );

  always #4 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  logic [31:0]   q_d[$];
  logic [HW-1:0] q_h[$];
  logic [31:0]   q_t[$];
  logic [HW-1:0] m_hdl = 1;
  int            m_ocnt = 0;
  logic [31:0]   m_ofirst = 0, m_olast = 0, ts_ctr = 100;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [HW-1:0] next_h(input logic [HW-1:0] h);
    logic [HW-1:0] n = h + 1'b1;
    return (n == 0) ? HW'(1) : n;
  endfunction

  function automatic logic [D*HW-1:0] head_vec();
    logic [D*HW-1:0] v = '0;
    for (int i = 0; i < q_h.size() && i < D; i++) v[i*HW +: HW] = q_h[i];
    return v;
  endfunction

  task automatic model_ins(input logic [31:0] d, input logic [31:0] ts);
    if (q_d.size() == D) begin
      if (m_ocnt == 0) m_ofirst = ts;
      m_ocnt++;
      m_olast = ts;
    end else begin
      q_d.push_back(d); q_h.push_back(m_hdl); q_t.push_back(ts);
      m_hdl = next_h(m_hdl);
    end
  endtask

  task automatic do_ins(input logic [31:0] d);
    bit exp_irq;
    ts_ctr += 7;
    @(negedge clk);
    ins_req = 1; ins_data = d; ins_ts = ts_ctr;
    exp_irq = (q_d.size() == 0);
    model_ins(d, ts_ctr);
    @(negedge clk);
    ins_req = 0;
    chk(irq_req == exp_irq, "R5 irq pulse", irq_req, exp_irq);
    chk(log_status == 1'b1, "R6 status after insert", log_status, 1);
  endtask

  task automatic do_rd(input int mx);
    int n;
    n = (mx < q_d.size()) ? mx : q_d.size();
    @(negedge clk);
    rd_req = 1; rd_max = CW'(mx);
    @(negedge clk);
    rd_req = 0;
    for (int j = 0; j < n; j++) begin
      chk(rec_valid == 1'b1, "R7 stream valid", rec_valid, 1);
      chk(rec_handle == q_h[j], "R3 handle", rec_handle, q_h[j]);
      chk(rec_data == q_d[j], "R4 data order", rec_data, q_d[j]);
      chk(rec_ts == q_t[j], "R4 timestamp", rec_ts, q_t[j]);
      @(negedge clk);
    end
    chk(rd_done == 1'b1 && rec_valid == 1'b0, "R7 done beat", {rd_done, rec_valid}, 2'b10);
    chk(rd_num == CW'(n), "R7 count returned", rd_num, n);
    chk(rd_more == (q_d.size() != 0), "R8 more flag", rd_more, q_d.size() != 0);
    chk(rd_ovf == (m_ocnt != 0), "R8 overflow flag", rd_ovf, m_ocnt != 0);
    if (m_ocnt != 0) begin
      chk(rd_ovf_cnt == 16'(m_ocnt), "R2 overflow count", rd_ovf_cnt, m_ocnt);
      chk(rd_ovf_first == m_ofirst, "R2 first time", rd_ovf_first, m_ofirst);
      chk(rd_ovf_last == m_olast, "R2 last time", rd_ovf_last, m_olast);
    end
    @(negedge clk);
  endtask

  task automatic do_clr(input int num, input logic [D*HW-1:0] hv, input logic [1:0] exp_code);
    int take;
    @(negedge clk);
    clr_req = 1; clr_num = CW'(num); clr_handles = hv;
    @(negedge clk);
    clr_req = 0;
    chk(clr_done == 1'b1, "R12 clear answered next cycle", clr_done, 1);
    chk(clr_code == exp_code, exp_code == 0 ? "R10 clear accepted" : "R9 clear rejected", clr_code, exp_code);
    if (exp_code == 0) begin
      take = (num < q_d.size()) ? num : q_d.size();
      for (int k = 0; k < take; k++) begin
        void'(q_d.pop_front()); void'(q_h.pop_front()); void'(q_t.pop_front());
      end
      if (take > 0) begin m_ocnt = 0; m_ofirst = 0; m_olast = 0; end
    end
    chk(log_status == (q_d.size() != 0), "R6 status after clear", log_status, q_d.size() != 0);
  endtask

  task automatic t_reset();
    chk(log_status == 0 && irq_req == 0, "R6 reset status/irq", {log_status, irq_req}, 0);
    chk({ins_stall, rd_stall, clr_stall, rec_valid} == 0, "R12 idle stalls", {ins_stall, rd_stall, clr_stall, rec_valid}, 0);
    do_rd(4);
  endtask

  task automatic t_basic();
    do_ins(32'hA1); do_ins(32'hB2); do_ins(32'hC3);
    do_rd(2);   // R7 partial read leaves records
    do_rd(15);
  endtask

  task automatic t_reject();
    logic [D*HW-1:0] hv;
    hv = head_vec();
    hv[1*HW +: HW] = q_h[2];
    do_clr(2, hv, 2'd1);          // R9 out of order
    hv = head_vec();
    hv[0 +: HW] = '0;
    do_clr(1, hv, 2'd1);          // R9 zero handle
    do_rd(15);
  endtask

  task automatic t_accept();
    do_clr(2, head_vec(), 2'd0);  // R10
    do_rd(15);
  endtask

  task automatic t_overflow();
    while (q_d.size() < D) do_ins(32'h1000 + ts_ctr);
    for (int k = 0; k < 3; k++) do_ins(32'hDEAD0 + k);  // R1 dropped
    do_rd(15);
  endtask

  task automatic t_wipe();
    do_clr(1, head_vec(), 2'd0);  // R10 overflow reset
    do_rd(15);
  endtask

  task automatic t_over_count();
    do_clr(15, head_vec(), 2'd0); // R11
    chk(q_d.size() == 0, "R11 model empty", q_d.size(), 0);
    do_rd(15);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 20; k++) begin  // R3 wrap skips zero
      do_ins(32'h5000 + k);
      do_rd(1);
      do_clr(1, head_vec(), 2'd0);
    end
  endtask

  task automatic t_arb();
    do_ins(32'h77);
    @(negedge clk);
    clr_req = 1; clr_num = 1; clr_handles = head_vec();
    rd_req = 1; rd_max = 4;
    ins_req = 1; ins_data = 32'hABCD; ts_ctr += 7; ins_ts = ts_ctr;
    #1;
    chk({clr_stall, rd_stall, ins_stall} == 3'b011, "R12 clear wins", {clr_stall, rd_stall, ins_stall}, 3'b011);
    @(negedge clk);
    chk(clr_done && clr_code == 0, "R12 clear first", {clr_done, clr_code}, 3'b100);
    void'(q_d.pop_front()); void'(q_h.pop_front()); void'(q_t.pop_front());
    clr_req = 0;
    #1;
    chk({rd_stall, ins_stall} == 2'b01, "R12 read before insert", {rd_stall, ins_stall}, 2'b01);
    @(negedge clk);
    chk(rd_done && rd_num == 0, "R12 read after clear sees empty", {rd_done, rd_num}, 5'b10000);
    rd_req = 0;
    #1;
    chk(ins_stall == 1'b1, "R12 stall while read completes", ins_stall, 1);
    @(negedge clk);
    chk(ins_stall == 1'b0, "R12 insert released", ins_stall, 0);
    model_ins(32'hABCD, ts_ctr);
    @(negedge clk);
    ins_req = 0;
    chk(irq_req == 1'b1, "R5 irq after arbitration", irq_req, 1);
    do_rd(15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_reject();
    t_accept();
    t_overflow();
    t_wipe();
    t_over_count();
    t_wrap();
    t_arb();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule